// File: doc/BRIEF.md
# Half-Warp Memory Request Coalescer

This block accepts one memory request issued together by sixteen parallel lanes. Each lane gives a byte address and an enable bit, and all lanes share one element size. The block decides whether the request fits one aligned burst. If it does not, it breaks the request into separate aligned transactions. It then hands the resulting transactions downstream, one per accepted handshake, each with an aligned base address and a per-byte enable mask. For the most recently accepted request it also reports whether the request merged and how many transactions it produced. A 32-lane request is presented as two consecutive sixteen-lane requests.

A request merges when all of the following hold:
- the element size is 4, 8 or 16 bytes;
- every enabled lane is aligned to that size;
- every enabled lane falls inside one region of sixteen elements, aligned to the region size.

In strict ordering mode, lane k must also address element k of that region. In relaxed mode, any arrangement inside the region is accepted. A request that does not merge is served as one 64-byte transaction for each distinct 64-byte segment its enabled lanes touch, issued in rising address order.

Top module: `coal_unit`

## Requirements
- R1: `in_ready` is high exactly when no request is in progress. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low, and the request inputs are ignored, until the edge that transfers the last transaction. `in_ready` is high again in the cycle after that edge.
- R2: A merging request with 4-byte elements yields a single transaction. Its address is the 64-byte-aligned region base, `out_wide` is 0, and `txn_count` is 1.
- R3: A merging request with 8-byte elements yields a single 128-byte transaction (`out_wide` = 1) at the 128-byte-aligned base. With 16-byte elements it yields two 128-byte transactions, at the 256-byte-aligned base and then at base + 128. The count is 2 in that case.
- R4: Disabled lanes never stop a request from merging, and they set no bits of any mask.
- R5: With `in_strict` = 1, lane k must sit at region base + k × size for the request to merge. With `in_strict` = 0, any placement of the lanes inside the region (including several lanes on one address) still merges.
- R6: Any element size other than 4, 8 or 16 (for example 12) never merges. Neither does a request with a lane that is misaligned to its element size, or with lanes spread over more than one region.
- R7: A non-merging request emits one transaction for each distinct 64-byte segment touched by any byte of an enabled lane. These come in strictly rising address order, with no repeats, and each has `out_wide` = 0 and mask bits 127..64 clear. `txn_count` equals the number of such segments.
- R8: A request with no enabled lane emits no transaction and reports `coalesced` = 0 and `txn_count` = 0. `in_ready` returns high one cycle after acceptance.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_mask` and `out_wide` hold their values.
- R10: `coalesced` and `txn_count` describe the last accepted request. They are valid from the cycle after acceptance until the next acceptance, and read 0 after reset. Mask bit b of any transaction enables byte `out_addr` + b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken (unit idle) |
| in_addr | input | LANES*ADDR_W | Byte address per lane, lane k in bits k*ADDR_W upward |
| in_active | input | LANES | Per-lane enable |
| in_size | input | SIZE_W | Element size in bytes, 1 to 16 |
| in_strict | input | 1 | 1 = strict lane order, 0 = relaxed |
| out_valid | output | 1 | Transaction offered |
| out_ready | input | 1 | Downstream accepts transaction |
| out_addr | output | ADDR_W | Aligned transaction base address |
| out_mask | output | MASK_W | Byte enables, bit b for byte out_addr+b |
| out_wide | output | 1 | 1 = 128-byte transaction, 0 = 64-byte |
| coalesced | output | 1 | Last request merged |
| txn_count | output | CNT_W | Transactions of last request |

## Verification
The hardest situation to reach is a fallback request that touches the maximum number of segments. In that case every enabled lane straddles a 64-byte boundary and the rising-order picker must work through 32 distinct candidates without skipping or repeating one. The stimulus builds it with 12-byte elements placed at a 256-byte stride, starting 8 bytes below a segment boundary, while the downstream ready toggles. A second hard case is a request offered while the unit is still busy. It is driven with the downstream stalled, so that the unit stays busy long enough to show that the second request changes nothing.

// File: rtl/coal_pkg.sv
`timescale 1ns/1ps
package coal_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } coal_state_e;

    // element sizes that may form a single burst
    function automatic logic size_mergeable(input int unsigned sz);
        return (sz == 4) || (sz == 8) || (sz == 16);
    endfunction

endpackage

// File: rtl/coal_lane.sv
`timescale 1ns/1ps
// Per-lane span: the segments a lane touches and its bytes inside a window.
module coal_lane #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 5,
    parameter int MASK_W = 128,
    parameter int SEG_LG = 6,
    localparam int SN_W  = ADDR_W - SEG_LG,
    localparam int EXT_W = MASK_W + (1 << SIZE_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              act,
    input  logic [ADDR_W-1:0] win,
    output logic [SN_W-1:0]   seg_lo,
    output logic [SN_W-1:0]   seg_hi,
    output logic [MASK_W-1:0] bytes
);
    logic [ADDR_W-1:0] end_b_d;
    logic [ADDR_W-1:0] fwd_d;
    logic [ADDR_W-1:0] back_d;
    logic [EXT_W-1:0]  ones_d;
    logic [EXT_W-1:0]  sh_d;

    always_comb begin
        end_b_d = addr + ADDR_W'(size) - ADDR_W'(1);
        seg_lo  = addr[ADDR_W-1:SEG_LG];
        seg_hi  = end_b_d[ADDR_W-1:SEG_LG];
        ones_d  = '0;
        for (int k = 0; k < (1 << SIZE_W); k++) begin
            if (k < int'(size)) ones_d[k] = 1'b1;
        end
        fwd_d  = addr - win;
        back_d = win - addr;
        sh_d   = '0;
        if (act) begin
            if (fwd_d < ADDR_W'(MASK_W)) begin
                sh_d = ones_d << fwd_d;
            end else if (back_d < ADDR_W'(size)) begin
                sh_d = ones_d >> back_d;
            end
        end
        bytes = sh_d[MASK_W-1:0];
    end
endmodule

// File: rtl/coal_rules.sv
`timescale 1ns/1ps
// Decides whether a stored request forms one aligned burst.
module coal_rules
    import coal_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 5,
    localparam int LN_LG = $clog2(LANES)
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES-1:0]        act,
    input  logic [SIZE_W-1:0]       size,
    input  logic                    strict,
    output logic                    ok,
    output logic [ADDR_W-1:0]       base
);
    logic [ADDR_W-1:0] region_m_d;
    logic [ADDR_W-1:0] first_d;
    logic [ADDR_W-1:0] lane_a_d;

    always_comb begin
        region_m_d = (ADDR_W'(size) << LN_LG) - ADDR_W'(1);
        first_d    = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (act[i]) first_d = addr[i*ADDR_W +: ADDR_W];
        end
        base     = first_d & ~region_m_d;
        ok       = size_mergeable(32'(size)) && (act != '0);
        lane_a_d = '0;
        for (int i = 0; i < LANES; i++) begin
            if (act[i]) begin
                lane_a_d = addr[i*ADDR_W +: ADDR_W];
                if ((lane_a_d & ~region_m_d) != base) ok = 1'b0;
                if ((lane_a_d & (ADDR_W'(size) - ADDR_W'(1))) != '0) ok = 1'b0;
                if (strict && ((lane_a_d - base) != ADDR_W'(i) * ADDR_W'(size))) ok = 1'b0;
            end
        end
    end
endmodule

// File: rtl/coal_pick.sv
`timescale 1ns/1ps
// Picks the lowest touched segment above the last one issued; counts distinct segments.
module coal_pick #(
    parameter int LANES = 16,
    parameter int SN_W  = 26,
    parameter int CNT_W = 6,
    localparam int NC   = 2 * LANES
) (
    input  logic [LANES*SN_W-1:0] lo,
    input  logic [LANES*SN_W-1:0] hi,
    input  logic [LANES-1:0]      act,
    input  logic [SN_W-1:0]       last,
    input  logic                  have_last,
    output logic [SN_W-1:0]       next_seg,
    output logic [CNT_W-1:0]      distinct
);
    logic [SN_W-1:0] cand [NC];
    logic [NC-1:0]   cv;

    for (genvar g = 0; g < LANES; g++) begin : g_cand
        assign cand[g]         = lo[g*SN_W +: SN_W];
        assign cand[g + LANES] = hi[g*SN_W +: SN_W];
        assign cv[g]           = act[g];
        assign cv[g + LANES]   = act[g];
    end

    always_comb begin
        logic found_d;
        logic dup_d;
        next_seg = '1;
        found_d  = 1'b0;
        for (int j = 0; j < NC; j++) begin
            if (cv[j] && (!have_last || cand[j] > last) && (!found_d || cand[j] < next_seg)) begin
                next_seg = cand[j];
                found_d  = 1'b1;
            end
        end
        distinct = '0;
        for (int j = 0; j < NC; j++) begin
            dup_d = 1'b0;
            for (int k = 0; k < j; k++) begin
                if (cv[k] && cand[k] == cand[j]) dup_d = 1'b1;
            end
            if (cv[j] && !dup_d) distinct = distinct + CNT_W'(1);
        end
    end
endmodule

// File: rtl/coal_unit.sv
`timescale 1ns/1ps
module coal_unit
    import coal_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 5,
    parameter int MASK_W  = 128,
    parameter int SEG_LG  = 6,
    parameter int WIDE_LG = 7,
    localparam int CNT_W  = $clog2(2 * LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_active,
    input  logic [SIZE_W-1:0]       in_size,
    input  logic                    in_strict,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [MASK_W-1:0]       out_mask,
    output logic                    out_wide,
    output logic                    coalesced,
    output logic [CNT_W-1:0]        txn_count
);
    localparam int SN_W      = ADDR_W - SEG_LG;
    localparam int SEG_BYTES = 1 << SEG_LG;

    typedef struct packed {
        coal_state_e             st;
        logic [CNT_W-1:0]        idx;
        logic                    have_last;
        logic [SN_W-1:0]         last;
        logic [LANES*ADDR_W-1:0] addr;
        logic [LANES-1:0]        act;
        logic [SIZE_W-1:0]       size;
        logic                    strict;
    } ctrl_t;

    ctrl_t q, d;

    logic                    rule_ok;
    logic [ADDR_W-1:0]       rule_base;
    logic [LANES*SN_W-1:0]   seg_lo_f;
    logic [LANES*SN_W-1:0]   seg_hi_f;
    logic [MASK_W-1:0]       lane_bytes [LANES];
    logic [MASK_W-1:0]       mask_or;
    logic [SN_W-1:0]         next_seg;
    logic [CNT_W-1:0]        distinct;
    logic [CNT_W-1:0]        total;
    logic [ADDR_W-1:0]       win;
    logic                    fire;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        coal_lane #(
            .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MASK_W(MASK_W), .SEG_LG(SEG_LG)
        ) u_lane (
            .addr  (q.addr[g*ADDR_W +: ADDR_W]),
            .size  (q.size),
            .act   (q.act[g]),
            .win   (win),
            .seg_lo(seg_lo_f[g*SN_W +: SN_W]),
            .seg_hi(seg_hi_f[g*SN_W +: SN_W]),
            .bytes (lane_bytes[g])
        );
    end

    coal_rules #(.LANES(LANES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_rules (
        .addr  (q.addr),
        .act   (q.act),
        .size  (q.size),
        .strict(q.strict),
        .ok    (rule_ok),
        .base  (rule_base)
    );

    coal_pick #(.LANES(LANES), .SN_W(SN_W), .CNT_W(CNT_W)) u_pick (
        .lo       (seg_lo_f),
        .hi       (seg_hi_f),
        .act      (q.act),
        .last     (q.last),
        .have_last(q.have_last),
        .next_seg (next_seg),
        .distinct (distinct)
    );

    // datapath and next state
    always_comb begin
        mask_or = '0;
        for (int i = 0; i < LANES; i++) mask_or = mask_or | lane_bytes[i];

        out_wide = rule_ok && (q.size != SIZE_W'(4));
        if (!rule_ok)                     total = distinct;
        else if (q.size == SIZE_W'(16))   total = CNT_W'(2);
        else                              total = CNT_W'(1);

        win = rule_ok ? rule_base + (ADDR_W'(q.idx) << WIDE_LG)
                      : {next_seg, {SEG_LG{1'b0}}};
        out_addr = win;
        for (int b = 0; b < MASK_W; b++) begin
            out_mask[b] = mask_or[b] && (out_wide || b < SEG_BYTES);
        end

        coalesced = rule_ok;
        txn_count = total;
        in_ready  = (q.st == ST_IDLE);
        out_valid = (q.st == ST_BUSY) && (q.idx < total);
        fire      = out_valid && out_ready;

        d = q;
        case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    d.st        = ST_BUSY;
                    d.idx       = '0;
                    d.have_last = 1'b0;
                    d.last      = '0;
                    d.addr      = in_addr;
                    d.act       = in_active;
                    d.size      = in_size;
                    d.strict    = in_strict;
                end
            end
            default: begin
                if (total == '0) begin
                    d.st = ST_IDLE;
                end else if (fire) begin
                    d.idx       = q.idx + CNT_W'(1);
                    d.last      = next_seg;
                    d.have_last = 1'b1;
                    if (q.idx + CNT_W'(1) == total) d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: unit never offers transactions while open for a new request
    p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R1: taking a request closes the input side
    p_take_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    // R9: a stalled transaction is held unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                    && $stable(out_mask) && $stable(out_wide));

    // R7: successive transactions of one request rise in address
    p_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid || (out_addr > $past(out_addr)));

    // R7: every fallback segment carries at least one enabled byte
    p_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !coalesced |-> out_mask != '0);

    // R3: a merged request yields one or two transactions
    p_merge_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        coalesced |-> (txn_count == CNT_W'(1)) || (txn_count == CNT_W'(2)));

    // R8: nothing is offered when the request produced no transaction
    p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_count == '0 |-> !out_valid);

    // R10: report outputs change only on acceptance
    p_report_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(txn_count) && $stable(coalesced));
endmodule

// File: tb/test_coal_unit.sv
`timescale 1ns/1ps
module test_coal_unit;
    localparam int L  = 16;
    localparam int AW = 32;
    localparam int SW = 5;
    localparam int MW = 128;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [L*AW-1:0] in_addr;
    logic [L-1:0]  in_active;
    logic [SW-1:0] in_size;
    logic          in_strict;
    logic          out_valid;
    logic          out_ready;
    logic [AW-1:0] out_addr;
    logic [MW-1:0] out_mask;
    logic          out_wide;
    logic          coalesced;
    logic [CW-1:0] txn_count;

    always #2 clk = ~clk;

    coal_unit i_coal_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_active(in_active), .in_size(in_size),
        .in_strict(in_strict), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_mask(out_mask), .out_wide(out_wide),
        .coalesced(coalesced), .txn_count(txn_count)
    );

    int checks = 0;
    int errors = 0;

    // kind: 0 contiguous, 1 reversed, 2 all same address, 3 stride 256
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] base;
        logic [4:0]  size;
        logic [15:0] act;
        logic        strict;
        logic        coal;
        logic [5:0]  cnt;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 32'h1000, 5'd4,  16'hFFFF, 1'b1, 1'b1, 6'd1},   // R2
        '{2'd0, 32'h2000, 5'd8,  16'hFFFF, 1'b1, 1'b1, 6'd1},   // R3
        '{2'd0, 32'h3000, 5'd16, 16'hFFFF, 1'b1, 1'b1, 6'd2},   // R3
        '{2'd0, 32'h1000, 5'd4,  16'h5A5A, 1'b1, 1'b1, 6'd1},   // R4
        '{2'd1, 32'h1040, 5'd4,  16'hFFFF, 1'b1, 1'b0, 6'd1},   // R5 strict
        '{2'd1, 32'h1040, 5'd4,  16'hFFFF, 1'b0, 1'b1, 6'd1},   // R5 relaxed
        '{2'd0, 32'h1004, 5'd4,  16'hFFFF, 1'b1, 1'b0, 6'd2},   // R6 misaligned start
        '{2'd0, 32'h4000, 5'd12, 16'hFFFF, 1'b1, 1'b0, 6'd3},   // R6 twelve-byte
        '{2'd3, 32'h0000, 5'd4,  16'hFFFF, 1'b0, 1'b0, 6'd16},  // R7 scattered
        '{2'd0, 32'h5000, 5'd16, 16'h00FF, 1'b0, 1'b1, 6'd2},   // R3 R4
        '{2'd1, 32'h6000, 5'd8,  16'hFFFF, 1'b0, 1'b1, 6'd1},   // R5
        '{2'd0, 32'h7002, 5'd4,  16'hFFFF, 1'b0, 1'b0, 6'd2},   // R6 unaligned element
        '{2'd3, 32'h8038, 5'd12, 16'hFFFF, 1'b0, 1'b0, 6'd32},  // R7 all straddle
        '{2'd2, 32'h9000, 5'd4,  16'hFFFF, 1'b0, 1'b1, 6'd1},   // R5 broadcast relaxed
        '{2'd2, 32'h9000, 5'd4,  16'hFFFF, 1'b1, 1'b0, 6'd1},   // R5 broadcast strict
        '{2'd0, 32'hA000, 5'd12, 16'h0001, 1'b1, 1'b0, 6'd1}    // R4 R6 single lane
    };

    logic [31:0]  lane_a  [L];
    logic [31:0]  ex_addr [32];
    logic [127:0] ex_mask [32];
    logic         ex_wide [32];
    int           ex_n;

    task automatic chk(input bit ok, input string req, input logic [127:0] a, input logic [127:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic build(input logic [1:0] kind, input logic [31:0] base, input logic [4:0] size);
        for (int i = 0; i < L; i++) begin
            case (kind)
                2'd0:    lane_a[i] = base + 32'(i) * 32'(size);
                2'd1:    lane_a[i] = base + 32'(15 - i) * 32'(size);
                2'd2:    lane_a[i] = base;
                default: lane_a[i] = base + 32'(i) * 32'h100;
            endcase
        end
    endtask

    function automatic logic [127:0] byte_mask(input logic [31:0] w, input int width,
                                               input logic [15:0] act, input logic [4:0] size);
        logic [127:0] m = '0;
        for (int i = 0; i < L; i++) begin
            if (act[i]) begin
                for (int k = 0; k < int'(size); k++) begin
                    logic [31:0] diff;
                    diff = lane_a[i] + 32'(k) - w;
                    if (diff < 32'(width)) m[diff[6:0]] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    task automatic model(input logic [15:0] act, input logic [4:0] size, input bit coal);
        ex_n = 0;
        if (coal) begin
            int f = 0;
            logic [31:0] region;
            logic [31:0] b;
            for (int i = L - 1; i >= 0; i--) if (act[i]) f = i;
            region = 32'(size) * 32'd16;
            b = lane_a[f] & ~(region - 32'd1);
            ex_n = (size == 5'd16) ? 2 : 1;
            for (int t = 0; t < ex_n; t++) begin
                ex_addr[t] = b + 32'(t) * 32'd128;
                ex_wide[t] = (size != 5'd4);
                ex_mask[t] = byte_mask(ex_addr[t], (size == 5'd4) ? 64 : 128, act, size);
            end
        end else begin
            for (int i = 0; i < L; i++) begin
                if (act[i]) begin
                    for (int k = 0; k < int'(size); k++) begin
                        logic [31:0] s;
                        bit seen;
                        s = (lane_a[i] + 32'(k)) & ~32'd63;
                        seen = 1'b0;
                        for (int j = 0; j < ex_n; j++) if (ex_addr[j] == s) seen = 1'b1;
                        if (!seen && ex_n < 32) begin
                            ex_addr[ex_n] = s;
                            ex_n++;
                        end
                    end
                end
            end
            for (int x = 0; x < ex_n; x++) begin
                for (int y = 0; y + 1 < ex_n - x; y++) begin
                    if (ex_addr[y] > ex_addr[y+1]) begin
                        logic [31:0] tmp;
                        tmp = ex_addr[y];
                        ex_addr[y] = ex_addr[y+1];
                        ex_addr[y+1] = tmp;
                    end
                end
            end
            for (int t = 0; t < ex_n; t++) begin
                ex_wide[t] = 1'b0;
                ex_mask[t] = byte_mask(ex_addr[t], 64, act, size);
            end
        end
    endtask

    task automatic send(input logic [15:0] act, input logic [4:0] size, input logic strict);
        @(negedge clk);
        for (int i = 0; i < L; i++) in_addr[i*AW +: AW] = lane_a[i];
        in_active = act;
        in_size   = size;
        in_strict = strict;
        in_valid  = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    function automatic string tx_tag(input bit coal, input logic [4:0] size, input logic [15:0] act);
        if (act != 16'hFFFF) return "R4";
        if (!coal)           return "R7";
        if (size == 5'd4)    return "R2";
        return "R3";
    endfunction

    // walk transactions of the accepted request until the unit is idle again
    task automatic collect(input bit coal, input logic [5:0] cnt, input string tag,
                           input string flag_tag, input bit stall, output int busy);
        int got = 0;
        bit held = 1'b0;
        logic [31:0] h_addr = '0;
        logic [127:0] h_mask = '0;
        busy = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (c == 0) begin
                chk(in_ready == 1'b0, "R1 busy after accept", 128'(in_ready), 128'(0));
                chk(coalesced == coal, flag_tag, 128'(coalesced), 128'(coal));
                chk(txn_count == cnt, "R10 count", 128'(txn_count), 128'(cnt));
            end
            if (held) begin
                chk(out_valid && out_addr == h_addr && out_mask == h_mask, "R9 hold",
                    {out_mask[95:0], out_addr}, {h_mask[95:0], h_addr});
                held = 1'b0;
            end
            if (in_ready) break;
            busy++;
            out_ready = stall ? ((c % 3) != 1) : 1'b1;
            if (out_valid) begin
                if (out_ready) begin
                    if (got < 32) begin
                        chk(out_addr == ex_addr[got], {tag, " addr"}, 128'(out_addr), 128'(ex_addr[got]));
                        chk(out_mask == ex_mask[got], {tag, " mask"}, out_mask, ex_mask[got]);
                        chk(out_wide == ex_wide[got], {tag, " wide"}, 128'(out_wide), 128'(ex_wide[got]));
                    end
                    got++;
                end else begin
                    held   = 1'b1;
                    h_addr = out_addr;
                    h_mask = out_mask;
                end
            end
        end
        chk(got == int'(cnt) && got == ex_n, {tag, " transaction total"}, 128'(got), 128'(cnt));
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int busy;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_addr = '0;
        in_active = '0;
        in_size = 5'd4;
        in_strict = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R1 idle, R10 report cleared
        chk(in_ready == 1'b1, "R1 reset ready", 128'(in_ready), 128'(1));
        chk(out_valid == 1'b0, "R1 reset valid", 128'(out_valid), 128'(0));
        chk(txn_count == '0, "R10 reset count", 128'(txn_count), 128'(0));
        chk(coalesced == 1'b0, "R10 reset flag", 128'(coalesced), 128'(0));

        // table walk
        for (int v = 0; v < NV; v++) begin
            string ftag;
            ftag = TBL[v].coal ? "R5 merge flag" : "R6 merge flag";
            build(TBL[v].kind, TBL[v].base, TBL[v].size);
            model(TBL[v].act, TBL[v].size, TBL[v].coal);
            send(TBL[v].act, TBL[v].size, TBL[v].strict);
            collect(TBL[v].coal, TBL[v].cnt, tx_tag(TBL[v].coal, TBL[v].size, TBL[v].act),
                    ftag, (v % 2) == 1, busy);
        end

        // R8: no enabled lane
        build(2'd0, 32'hB000, 5'd4);
        model(16'h0000, 5'd4, 1'b0);
        send(16'h0000, 5'd4, 1'b1);
        collect(1'b0, 6'd0, "R8", "R8 flag", 1'b0, busy);
        chk(busy == 1, "R8 busy cycles", 128'(busy), 128'(1));

        // R1: request offered while busy is ignored; R9 stall holds first transaction
        build(2'd3, 32'h0000, 5'd4);
        model(16'hFFFF, 5'd4, 1'b0);
        send(16'hFFFF, 5'd4, 1'b0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_addr   = '0;
            in_active = 16'h0001;
            in_size   = 5'd8;
            out_ready = 1'b0;
            chk(in_ready == 1'b0, "R1 ignore while busy", 128'(in_ready), 128'(0));
            chk(out_valid && out_addr == ex_addr[0], "R9 stalled addr", 128'(out_addr), 128'(ex_addr[0]));
        end
        collect(1'b0, 6'd16, "R1 R7", "R6 merge flag", 1'b1, busy);
        chk(txn_count == 6'd16, "R10 report kept", 128'(txn_count), 128'(16));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule